// File: doc/BRIEF.md
# Looping Shift Register With Chance

This block is a clocked bit register of eight stages that moves its contents one stage per rising edge of an external step clock. The new bit that enters the chain is chosen at each step from a feedback stage, the loop point, whose position is set by a length value. The length value is a base setting plus a signed modulation offset, clamped to one through eight. A chance setting decides at each step whether the loop-point bit comes back unchanged or is combined by XOR with an external data bit. The random draw comes from a free-running pseudo-random sequence.

A gate input and a push-button input each reverse the shift direction. A write input forces a one into the entry stage. All external control and data inputs are asynchronous to the system clock. They are resynchronized, and the step clock, gate and button are edge-detected. The full stage vector drives a display, and a one-bit tap gives the bit most recently loaded. A typical use is a looping gate pattern whose length can change while it runs.

Top module: `loop_shift_chance`

## Requirements
- R1: A synchronous active-high reset clears every stage and the tap, and leaves the direction forward. Forward means the entry stage is bit 0 of `state_o`.
- R2: Stages and tap change only on a detected rising edge of `step_in`. With no such edge, changes on write, data or chance leave `state_o` and `tap_o` as they were.
- R3: In the forward direction, each step loads the entry bit into bit 0 and moves bit i-1 into bit i.
- R4: In the reverse direction, each step loads the entry bit into bit 7 and moves bit i+1 into bit i.
- R5: A rising edge on `dir_gate_in` reverses the direction, and so does a rising edge on `dir_button_in`. Edges on both in the same system cycle reverse it only once.
- R6: The length is `len_base` (unsigned) plus `len_mod` (two's complement), clamped to 1..8. The loop point is bit length-1 going forward and bit 8-length in reverse. A length of 1 feeds the entry stage from itself.
- R7: With `chance` at 255 and no write, the entry bit equals the loop-point bit whatever `data_in` is.
- R8: With `chance` at 0 and no write, the entry bit equals the loop-point bit XOR `data_in`.
- R9: At an intermediate `chance`, each step picks recirculation or the XOR path from the pseudo-random value. Over many steps both outcomes occur.
- R10: A step taken while `write_in` is high loads a one into the entry stage, whatever the chance and data values.
- R11: Changing the length moves no stored bits. Ones that lie beyond the new loop point are never fed back, so they shift out and are lost.
- R12: `tap_o` holds the bit loaded into the entry stage at the most recent step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Asynchronous step clock; each rising edge advances the register |
| dir_gate_in | input | 1 | Asynchronous gate; each rising edge reverses direction |
| dir_button_in | input | 1 | Asynchronous button; each rising edge reverses direction |
| write_in | input | 1 | Asynchronous; when high, a step loads a one |
| data_in | input | 1 | Asynchronous external data bit for the XOR path |
| len_base | input | LEN_W (4) | Base length setting, unsigned |
| len_mod | input | LEN_W+1 (5) | Length modulation offset, two's complement |
| chance | input | CHANCE_W (8) | Recirculation probability; 255 always loops, 0 always XORs |
| state_o | output | STAGES (8) | All stage bits, bit 0 is stage 1 |
| tap_o | output | 1 | Most recently entered bit |

## Verification
The bench builds the block with its default parameters: eight stages, an 8-bit chance value and a 16-bit sequence generator. At this size every base setting from 0 to 15 can be combined with every offset from -8 to +8. That sweep reaches both clamp limits and every loop point, and a full lap of the loop is compared for each combination. The two extreme chance values make the entry bit fully predictable, so a bench model can follow every step in both directions. The random middle setting is judged by the spread of outcomes over many steps.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } lsc_dir_e;

  // Clamp a signed length sum into the legal loop range 1..max_len.
  function automatic int clamp_len(input int raw, input int max_len);
    if (raw < 1) return 1;
    if (raw > max_len) return max_len;
    return raw;
  endfunction

endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [DEPTH-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[DEPTH-2:0], din[b]};
    end
    assign dout[b] = sh[DEPTH-1];
  end

endmodule

// File: rtl/lsc_chance.sv
module lsc_chance #(
  parameter int              CHANCE_W  = 8,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANCE_W-1:0] chance,
  output logic                take_xor
);

  localparam logic [CHANCE_W-1:0] CHANCE_MAX = {CHANCE_W{1'b1}};

  logic [LFSR_W-1:0]   lfsr_q;
  logic [CHANCE_W-1:0] rnd;

  // Free-running Galois sequence generator, advances every system cycle.
  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= LFSR_SEED;
    else     lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);
  end

  assign rnd = lfsr_q[LFSR_W-1 -: CHANCE_W];

  // Full-scale chance pins the decision to recirculation.
  assign take_xor = (chance != CHANCE_MAX) && (rnd >= chance);

endmodule

// File: rtl/lsc_stages.sv
module lsc_stages
  import lsc_pkg::*;
#(
  parameter int STAGES = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  lsc_dir_e          dir,
  input  logic [LEN_W-1:0]  len,
  input  logic              write,
  input  logic              data,
  input  logic              take_xor,
  output logic [STAGES-1:0] state,
  output logic              tap,
  output logic              loop_bit
);

  localparam int IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] nxt;
  logic [IDX_W-1:0]  loop_idx;
  logic              entry;
  logic              tap_q;

  always_comb begin
    if (dir == DIR_REV) loop_idx = IDX_W'(STAGES - int'(len));
    else                loop_idx = IDX_W'(int'(len) - 1);
  end

  assign loop_bit = state_q[loop_idx];
  assign entry    = write ? 1'b1 : (loop_bit ^ (take_xor & data));

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic fwd_src;
    logic rev_src;
    if (i == 0) begin : g_fwd_head
      assign fwd_src = entry;
    end else begin : g_fwd_body
      assign fwd_src = state_q[i-1];
    end
    if (i == STAGES-1) begin : g_rev_head
      assign rev_src = entry;
    end else begin : g_rev_body
      assign rev_src = state_q[i+1];
    end
    assign nxt[i] = (dir == DIR_REV) ? rev_src : fwd_src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      tap_q   <= 1'b0;
    end else if (step) begin
      state_q <= nxt;
      tap_q   <= entry;
    end
  end

  assign state = state_q;
  assign tap   = tap_q;

endmodule

// File: rtl/loop_shift_chance.sv
module loop_shift_chance
  import lsc_pkg::*;
#(
  parameter int                STAGES     = 8,
  parameter int                LEN_W      = $clog2(STAGES + 1),
  parameter int                CHANCE_W   = 8,
  parameter int                LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'hACE1,
  parameter int                SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_in,
  input  logic                dir_gate_in,
  input  logic                dir_button_in,
  input  logic                write_in,
  input  logic                data_in,
  input  logic [LEN_W-1:0]    len_base,
  input  logic signed [LEN_W:0] len_mod,
  input  logic [CHANCE_W-1:0] chance,
  output logic [STAGES-1:0]   state_o,
  output logic                tap_o
);

  localparam int N_EDGE = 3;
  localparam int N_LVL  = 2;

  logic [N_EDGE-1:0] edge_lvl;
  logic [N_EDGE-1:0] edge_prev;
  logic [N_EDGE-1:0] edge_rise;
  logic [N_LVL-1:0]  lvl_sync;

  logic               step;
  logic               write_lvl;
  logic               data_lvl;
  lsc_dir_e           dir_q;
  logic               dir_flip;
  logic signed [LEN_W+1:0] len_sum;
  logic [LEN_W-1:0]   len_q;
  logic               take_xor;
  logic               loop_bit;

  lsc_sync #(.W(N_EDGE), .DEPTH(SYNC_DEPTH)) u_sync_edge (
    .clk  (clk),
    .rst  (rst),
    .din  ({dir_button_in, dir_gate_in, step_in}),
    .dout (edge_lvl)
  );

  lsc_sync #(.W(N_LVL), .DEPTH(SYNC_DEPTH)) u_sync_lvl (
    .clk  (clk),
    .rst  (rst),
    .din  ({data_in, write_in}),
    .dout (lvl_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) edge_prev <= '0;
    else     edge_prev <= edge_lvl;
  end

  assign edge_rise = edge_lvl & ~edge_prev;
  assign step      = edge_rise[0];
  assign dir_flip  = edge_rise[1] | edge_rise[2];
  assign write_lvl = lvl_sync[0];
  assign data_lvl  = lvl_sync[1];

  always_ff @(posedge clk) begin
    if (rst)           dir_q <= DIR_FWD;
    else if (dir_flip) dir_q <= (dir_q == DIR_FWD) ? DIR_REV : DIR_FWD;
  end

  assign len_sum = $signed({2'b00, len_base}) + $signed({len_mod[LEN_W], len_mod});

  always_ff @(posedge clk) begin
    if (rst) len_q <= LEN_W'(STAGES);
    else     len_q <= LEN_W'(clamp_len(int'(len_sum), STAGES));
  end

  lsc_chance #(
    .CHANCE_W  (CHANCE_W),
    .LFSR_W    (LFSR_W),
    .LFSR_TAPS (LFSR_TAPS),
    .LFSR_SEED (LFSR_SEED)
  ) u_chance (
    .clk      (clk),
    .rst      (rst),
    .chance   (chance),
    .take_xor (take_xor)
  );

  lsc_stages #(.STAGES(STAGES), .LEN_W(LEN_W)) u_stages (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .dir      (dir_q),
    .len      (len_q),
    .write    (write_lvl),
    .data     (data_lvl),
    .take_xor (take_xor),
    .state    (state_o),
    .tap      (tap_o),
    .loop_bit (loop_bit)
  );

endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int STAGES   = 8,
  parameter int LEN_W    = 4,
  parameter int CHANCE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                step,
  input logic                dir,
  input logic                write_lvl,
  input logic                data_lvl,
  input logic                loop_bit,
  input logic [LEN_W-1:0]    len,
  input logic [CHANCE_W-1:0] chance,
  input logic [STAGES-1:0]   state_o,
  input logic                tap_o
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state_o == '0 && tap_o == 1'b0 && dir == 1'b0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(state_o) && $stable(tap_o))); // R2

  AST_FWD_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (step && !dir) |=> state_o[STAGES-1:1] == $past(state_o[STAGES-2:0])); // R3

  AST_REV_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (step && dir) |=> state_o[STAGES-2:0] == $past(state_o[STAGES-1:1])); // R4

  AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (int'(len) >= 1 && int'(len) <= STAGES)); // R6

  AST_CHANCE_MAX_LOOP: assert property (@(posedge clk) disable iff (rst)
    (step && !write_lvl && chance == {CHANCE_W{1'b1}}) |=> tap_o == $past(loop_bit)); // R7

  AST_CHANCE_MIN_XOR: assert property (@(posedge clk) disable iff (rst)
    (step && !write_lvl && chance == '0) |=> tap_o == $past(loop_bit ^ data_lvl)); // R8

  AST_WRITE_ONE: assert property (@(posedge clk) disable iff (rst)
    (step && write_lvl) |=> tap_o); // R10

  AST_TAP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    step |=> tap_o == ($past(dir) ? state_o[STAGES-1] : state_o[0])); // R12

endmodule

bind loop_shift_chance lsc_checker #(
  .STAGES   (STAGES),
  .LEN_W    (LEN_W),
  .CHANCE_W (CHANCE_W)
) u_lsc_checker (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .dir       (dir_q),
  .write_lvl (write_lvl),
  .data_lvl  (data_lvl),
  .loop_bit  (loop_bit),
  .len       (len_q),
  .chance    (chance),
  .state_o   (state_o),
  .tap_o     (tap_o)
);

// File: tb/test_loop_shift_chance.sv
module test_loop_shift_chance;

  localparam int S = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              step_in, dir_gate_in, dir_button_in, write_in, data_in;
  logic [3:0]        len_base;
  logic signed [4:0] len_mod;
  logic [7:0]        chance;
  logic [S-1:0]      state_o;
  logic              tap_o;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  logic [S-1:0] ms;
  logic         md;
  logic         mt;

  always #4 clk = ~clk;

  loop_shift_chance i_loop_shift_chance (
    .clk           (clk),
    .rst           (rst),
    .step_in       (step_in),
    .dir_gate_in   (dir_gate_in),
    .dir_button_in (dir_button_in),
    .write_in      (write_in),
    .data_in       (data_in),
    .len_base      (len_base),
    .len_mod       (len_mod),
    .chance        (chance),
    .state_o       (state_o),
    .tap_o         (tap_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int b, input int m);
    int r;
    r = b + m;
    if (r < 1) r = 1;
    if (r > S) r = S;
    return r;
  endfunction

  task automatic model_step(input bit wr, input bit d, input bit xp, input int ln);
    logic lb, en;
    lb = md ? ms[S-ln] : ms[ln-1];
    en = wr ? 1'b1 : (xp ? (lb ^ d) : lb);
    ms = md ? {en, ms[S-1:1]} : {ms[S-2:0], en};
    mt = en;
  endtask

  task automatic pulse_step(input bit wr, input bit d);
    @(negedge clk);
    write_in = wr; data_in = d; step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0; write_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic step_cmp(input bit wr, input bit d, input bit xp,
                          input int ln, input string req);
    pulse_step(wr, d);
    model_step(wr, d, xp, ln);
    check(state_o == ms && tap_o == mt, req, {23'b0, tap_o, state_o}, {23'b0, mt, ms});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step_in = 1'b0; write_in = 1'b0;
    dir_gate_in = 1'b0; dir_button_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    ms = '0; md = 1'b0; mt = 1'b0;
  endtask

  task automatic pulse_dir(input bit g, input bit b);
    @(negedge clk);
    dir_gate_in = g; dir_button_in = b;
    repeat (4) @(negedge clk);
    dir_gate_in = 1'b0; dir_button_in = 1'b0;
    repeat (4) @(negedge clk);
    md = ~md;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int nr, nx, ln;
    logic [S-1:0] old;
    rst = 1'b1; step_in = 1'b0; dir_gate_in = 1'b0; dir_button_in = 1'b0;
    write_in = 1'b0; data_in = 1'b0; len_base = 4'd8; len_mod = '0; chance = 8'd255;

    // R1: reset state
    do_reset();
    check(state_o == '0 && tap_o == 1'b0, "R1", {23'b0, tap_o, state_o}, 32'h0);

    // R6/R7/R10/R12: every base and offset, forward, full-scale chance, data held high
    chance = 8'd255;
    for (int b = 0; b < 16; b++) begin
      for (int m = -8; m <= 8; m++) begin
        do_reset();
        len_base = 4'(b); len_mod = 5'(m);
        ln = exp_len(b, m);
        step_cmp(1'b1, 1'b1, 1'b0, ln, "R10 R1");
        for (int k = 0; k <= ln; k++) step_cmp(1'b0, 1'b1, 1'b0, ln, "R6 R7 R12");
      end
    end

    // R2: no step edge, other inputs toggle
    do_reset();
    len_base = 4'd8; len_mod = '0; chance = 8'd255;
    step_cmp(1'b1, 1'b0, 1'b0, 8, "R10");
    @(negedge clk);
    write_in = 1'b1; data_in = 1'b1; chance = 8'd0;
    repeat (10) @(negedge clk);
    check(state_o == ms && tap_o == mt, "R2", {23'b0, tap_o, state_o}, {23'b0, mt, ms});
    write_in = 1'b0; data_in = 1'b0; chance = 8'd255;
    repeat (4) @(negedge clk);

    // R11: ones beyond a shortened loop are lost
    do_reset();
    len_base = 4'd8; len_mod = '0; chance = 8'd255; data_in = 1'b0;
    step_cmp(1'b1, 1'b0, 1'b0, 8, "R3");
    step_cmp(1'b1, 1'b0, 1'b0, 8, "R3");
    for (int k = 0; k < 6; k++) step_cmp(1'b0, 1'b0, 1'b0, 8, "R3");
    check(state_o == 8'hC0, "R11", {24'b0, state_o}, 32'hC0);
    len_base = 4'd6;
    step_cmp(1'b0, 1'b0, 1'b0, 6, "R11");
    step_cmp(1'b0, 1'b0, 1'b0, 6, "R11");
    check(state_o == 8'h00, "R11", {24'b0, state_o}, 32'h0);
    for (int k = 0; k < 8; k++) pulse_step(1'b0, 1'b0);
    check(state_o == 8'h00, "R11", {24'b0, state_o}, 32'h0);

    // R4/R5: direction reversal by gate, button, and both together
    do_reset();
    len_base = 4'd3; len_mod = '0; chance = 8'd255;
    pulse_dir(1'b1, 1'b0);
    step_cmp(1'b1, 1'b0, 1'b0, 3, "R5");
    check(state_o == 8'h80, "R5", {24'b0, state_o}, 32'h80);
    for (int k = 0; k < 5; k++) step_cmp(1'b0, 1'b0, 1'b0, 3, "R4");
    pulse_dir(1'b0, 1'b1);
    step_cmp(1'b1, 1'b0, 1'b0, 3, "R5");
    for (int k = 0; k < 3; k++) step_cmp(1'b0, 1'b0, 1'b0, 3, "R5");
    pulse_dir(1'b1, 1'b1);
    step_cmp(1'b1, 1'b0, 1'b0, 3, "R5");
    for (int k = 0; k < 3; k++) step_cmp(1'b0, 1'b0, 1'b0, 3, "R4");

    // R8: zero chance, XOR path, both directions
    do_reset();
    len_base = 4'd3; len_mod = '0; chance = 8'd0;
    for (int k = 0; k < 12; k++) step_cmp(1'b0, 1'b1, 1'b1, 3, "R8");
    for (int k = 0; k < 4; k++) step_cmp(1'b0, 1'b0, 1'b1, 3, "R8");
    pulse_dir(1'b1, 1'b0);
    for (int k = 0; k < 8; k++) step_cmp(1'b0, 1'b1, 1'b1, 3, "R8");

    // R9: intermediate chance, length 1, data high
    do_reset();
    len_base = 4'd1; len_mod = '0; chance = 8'd128;
    nr = 0; nx = 0;
    for (int k = 0; k < 64; k++) begin
      old = state_o;
      pulse_step(1'b0, 1'b1);
      check(state_o[S-1:1] == old[S-2:0], "R3", {25'b0, state_o[S-1:1]}, {25'b0, old[S-2:0]});
      if (state_o[0] == old[0]) nr++;
      else                      nx++;
    end
    check(nr > 0, "R9", nr, 1);
    check(nx > 0, "R9", nx, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule